// File: doc/BRIEF.md
# Policy-Configurable Countdown Timer

This block is a down-counter that can run periodically or as a one-shot. Each pulse on a tick-enable input lowers the count by one. When the count expires, the block raises a trigger that lasts one clock. A separate prescaler outside the block supplies the tick-enable pulses. Software-side inputs do four jobs: load a reload limit (optionally copying it into the count), write the count directly, start the timer in either mode, and stop it. The registered count and a readback value are always visible.

The behaviour at zero crossings and on writes depends on a policy bitmask that is fixed at elaboration. The policy can defer the reload, suppress the immediate trigger, trigger only on a decrement, keep a zero-limit timer firing, add one tick before the periodic wrap, or round the readback upward. Suppressing the immediate trigger and triggering only on a decrement contradict each other, so elaboration stops with an error if both are set.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count is 0, the mode is disabled, the trigger is low and the readback is 0. The mode output is encoded as 0 = disabled, 1 = periodic, 2 = one-shot.
- R2: A periodic timer with limit L≥1 and a tick every cycle counts L, L-1, ..., 1. On the tick taken at count 1 it raises a one-cycle trigger and reloads L, so it fires once every L ticks.
- R3: A one-shot timer takes a tick at count 1, then goes to count 0 and disabled mode and raises one trigger. Later ticks change nothing and raise no trigger.
- R4: Default policy: a start or write leaves the running count at 0, which triggers at once and reloads the limit at once. If the limit is also 0, the timer goes to disabled instead.
- R5: Policy bit 2 (quiet load) raises no trigger when a start or write leaves the count at zero. If the count stays at zero, it holds for one tick, and the trigger fires on the tick that takes it off zero.
- R6: Policy bit 3 (deferred reload) applies when a start or write leaves a periodic count at 0 with a nonzero limit. The count then holds at 0 for one tick, and the next tick loads the limit without a trigger.
- R7: Policy bit 0 (extra wrap tick) makes every periodic decrement to 0 hold count 0 for one tick with no trigger. The next tick triggers and reloads, so the period is L+1 ticks.
- R8: Policy bit 5 (decrement-only trigger) means a start or write that leaves the count at 0 never triggers. A decrement that reaches expiry still does.
- R9: Policy bit 1 (continuous) lets a periodic timer with limit 0 stay periodic and trigger on every tick. Without it, such a timer goes to disabled.
- R10: Stop sets the mode to disabled and keeps the count. Stop wins over a start in the same cycle.
- R11: Starting a timer that is already running changes only its mode. The count is kept.
- R12: A limit write changes the count only when its reload flag is set. In a cycle with a count write or a limit-with-reload write, a tick is ignored.
- R13: The readback equals the count. Under policy bit 4 (round-up) it equals count+1 while the timer runs, except in the cycle right after a load or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from the prescaler |
| start | input | 1 | Start request |
| start_oneshot | input | 1 | Mode for start: 1 one-shot, 0 periodic |
| stop | input | 1 | Stop request |
| cnt_wr | input | 1 | Write the count |
| cnt_wdata | input | W | Count write value |
| lim_wr | input | 1 | Write the limit |
| lim_wdata | input | W | Limit write value |
| lim_reload | input | 1 | With lim_wr, also copy the limit into the count |
| count | output | W | Registered count |
| rd_count | output | W+1 | Readback value with policy rounding |
| mode | output | 2 | Mode: 0 disabled, 1 periodic, 2 one-shot |
| trigger | output | 1 | One-cycle expiry pulse |

## Verification
Two functions can collide in the same cycle: a software write and a tick, and a stop and a start. The bench steps a periodic timer down to count 1. It then drives a count write together with the tick that would expire it, and expects the written value with no trigger. It also drives stop and start together on a running timer, and expects disabled mode with the count unchanged. Seven instances, one per policy, run the same stimulus side by side. Limits 1 to 4 are swept, and trigger counts are compared with L-tick or (L+1)-tick periods computed in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_PER = 2'd1,
    MODE_ONE = 2'd2
  } tmr_mode_e;

  // Policy bit positions
  localparam int POL_WRAP     = 0;
  localparam int POL_CONT     = 1;
  localparam int POL_QUIET    = 2;
  localparam int POL_DEFER    = 3;
  localparam int POL_ROUNDUP  = 4;
  localparam int POL_DEC_ONLY = 5;
  localparam int POL_BITS     = 6;

  function automatic bit pol_has(logic [POL_BITS-1:0] p, int b);
    return p[b];
  endfunction

endpackage

// File: rtl/tmr_load_eval.sv
module tmr_load_eval
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [POL_BITS-1:0] POLICY = '0
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lim,
  input  tmr_mode_e    mode_req,
  output logic [W-1:0] n_count,
  output tmr_mode_e    n_mode,
  output logic         n_trig
);
  localparam bit P_CONT  = pol_has(POLICY, POL_CONT);
  localparam bit P_QUIET = pol_has(POLICY, POL_QUIET);
  localparam bit P_DEFER = pol_has(POLICY, POL_DEFER);
  localparam bit P_DEC   = pol_has(POLICY, POL_DEC_ONLY);

  logic [W-1:0] refill;
  logic         keep_run;

  always_comb begin
    refill   = P_DEFER ? '0 : lim;
    keep_run = (P_CONT && mode_req == MODE_PER && lim == '0)
             || P_QUIET
             || (P_DEFER && mode_req == MODE_PER && lim != '0);
    n_count  = val;
    n_mode   = mode_req;
    n_trig   = 1'b0;
    if (val == '0) begin
      n_trig = !P_QUIET && !P_DEC;
      if (refill != '0) begin
        n_count = refill;
      end else begin
        n_count = '0;
        n_mode  = keep_run ? mode_req : MODE_OFF;
      end
    end
  end
endmodule

// File: rtl/tmr_tick_eval.sv
module tmr_tick_eval
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [POL_BITS-1:0] POLICY = '0
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lim,
  input  tmr_mode_e    mode_cur,
  input  logic         whold,
  output logic [W-1:0] n_count,
  output tmr_mode_e    n_mode,
  output logic         n_trig,
  output logic         n_whold,
  output logic         n_reload
);
  localparam bit P_WRAP  = pol_has(POLICY, POL_WRAP);
  localparam bit P_CONT  = pol_has(POLICY, POL_CONT);
  localparam bit P_QUIET = pol_has(POLICY, POL_QUIET);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    n_count  = cnt;
    n_mode   = mode_cur;
    n_trig   = 1'b0;
    n_whold  = 1'b0;
    n_reload = 1'b0;
    if (cnt > ONE) begin
      n_count = cnt - ONE;
    end else if (mode_cur == MODE_ONE) begin
      n_count = '0;
      n_mode  = MODE_OFF;
      n_trig  = 1'b1;
    end else if (cnt == ONE && P_WRAP && lim != '0) begin
      n_count = '0;
      n_whold = 1'b1;
    end else begin
      n_trig   = (cnt == ONE) || whold || P_QUIET || (lim == '0);
      n_count  = lim;
      n_reload = 1'b1;
      if (lim == '0 && !P_CONT) n_mode = MODE_OFF;
    end
  end
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [POL_BITS-1:0] POLICY = '0
) (
  input  logic [W-1:0] cnt,
  input  logic         run,
  input  logic         fresh,
  output logic [W:0]   rd
);
  localparam bit P_RUP = pol_has(POLICY, POL_ROUNDUP);

  always_comb begin
    rd = {1'b0, cnt};
    if (P_RUP && run && !fresh) rd = {1'b0, cnt} + (W+1)'(1);
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [POL_BITS-1:0] POLICY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         start_oneshot,
  input  logic         stop,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         lim_wr,
  input  logic [W-1:0] lim_wdata,
  input  logic         lim_reload,
  output logic [W-1:0] count,
  output logic [W:0]   rd_count,
  output logic [1:0]   mode,
  output logic         trigger
);
  localparam bit P_QUIET = pol_has(POLICY, POL_QUIET);
  localparam bit P_DEC   = pol_has(POLICY, POL_DEC_ONLY);

  generate
    if (P_QUIET && P_DEC) begin : g_bad_policy
      $error("cdt_timer: quiet-load and decrement-only policies cannot be combined");
    end
  endgenerate

  logic [W-1:0] count_q, lim_q;
  tmr_mode_e    mode_q;
  logic         trig_q, whold_q, fresh_q;

  logic [W-1:0] count_n, lim_n, wr_val;
  tmr_mode_e    mode_n, mode_req;
  logic         trig_n, whold_n, fresh_n;

  // named events
  logic         running, wr_any, do_load, do_tick;

  logic [W-1:0] le_count, te_count;
  tmr_mode_e    le_mode, te_mode;
  logic         le_trig, te_trig, te_whold, te_reload;

  assign running  = (mode_q != MODE_OFF);
  assign lim_n    = lim_wr ? lim_wdata : lim_q;
  assign wr_any   = cnt_wr || (lim_wr && lim_reload);
  assign wr_val   = cnt_wr ? cnt_wdata : lim_wdata;
  assign mode_req = start ? (start_oneshot ? MODE_ONE : MODE_PER) : mode_q;
  assign do_load  = !stop && ((wr_any && running) || (start && !running));
  assign do_tick  = !stop && !wr_any && !do_load && tick && running;

  tmr_load_eval #(.W(W), .POLICY(POLICY)) u_load (
    .val      (wr_any ? wr_val : count_q),
    .lim      (lim_n),
    .mode_req (mode_req),
    .n_count  (le_count),
    .n_mode   (le_mode),
    .n_trig   (le_trig)
  );

  tmr_tick_eval #(.W(W), .POLICY(POLICY)) u_tick (
    .cnt      (count_q),
    .lim      (lim_n),
    .mode_cur (mode_req),
    .whold    (whold_q),
    .n_count  (te_count),
    .n_mode   (te_mode),
    .n_trig   (te_trig),
    .n_whold  (te_whold),
    .n_reload (te_reload)
  );

  always_comb begin
    count_n = count_q;
    mode_n  = mode_req;
    trig_n  = 1'b0;
    whold_n = whold_q;
    fresh_n = 1'b0;
    if (stop) begin
      mode_n  = MODE_OFF;
      whold_n = 1'b0;
      if (wr_any) count_n = wr_val;
    end else if (do_load) begin
      count_n = le_count;
      mode_n  = le_mode;
      trig_n  = le_trig;
      whold_n = 1'b0;
      fresh_n = 1'b1;
    end else if (wr_any) begin
      count_n = wr_val;
    end else if (do_tick) begin
      count_n = te_count;
      mode_n  = te_mode;
      trig_n  = te_trig;
      whold_n = te_whold;
      fresh_n = te_reload;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      lim_q   <= '0;
      mode_q  <= MODE_OFF;
      trig_q  <= 1'b0;
      whold_q <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      count_q <= count_n;
      lim_q   <= lim_n;
      mode_q  <= mode_n;
      trig_q  <= trig_n;
      whold_q <= whold_n;
      fresh_q <= fresh_n;
    end
  end

  tmr_readback #(.W(W), .POLICY(POLICY)) u_rd (
    .cnt   (count_q),
    .run   (running),
    .fresh (fresh_q),
    .rd    (rd_count)
  );

  assign count   = count_q;
  assign mode    = mode_q;
  assign trigger = trig_q;

  // ---------------- assertions ----------------
  logic quiet_in;
  assign quiet_in = !stop && !start && !wr_any;

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_in && tick && running && count > W'(1)) |=> (count == W'($past(count) - W'(1))));

  a_r3_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_in && tick && mode == 2'd2 && count == W'(1))
      |=> (mode == 2'd0 && trigger && count == '0));

  a_r10_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (mode == 2'd0));

  a_r10_stop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_any) |=> $stable(count));

  a_r11_restart_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (start && running && !stop && !wr_any && !tick) |=> $stable(count));

  a_r12_limit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && !lim_reload && !cnt_wr && !stop && !start && !tick) |=> $stable(count));

  generate
    if (P_DEC) begin : g_dec_chk
      a_r8_no_load_trig: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> !trigger);
    end
  endgenerate
endmodule

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
  localparam int W = 8;
  localparam int N = 7;
  // instance index: 0 default, 1 quiet, 2 defer, 3 wrap, 4 cont, 5 dec-only, 6 round-up
  function automatic logic [5:0] pol_of(int i);
    case (i)
      1: return 6'b000100;
      2: return 6'b001000;
      3: return 6'b000001;
      4: return 6'b000010;
      5: return 6'b100000;
      6: return 6'b010000;
      default: return 6'b000000;
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, start = 0, start_oneshot = 0, stop = 0;
  logic cnt_wr = 0, lim_wr = 0, lim_reload = 0;
  logic [W-1:0] cnt_wdata = '0, lim_wdata = '0;

  logic [W-1:0] cnt  [N];
  logic [W:0]   rdv  [N];
  logic [1:0]   md   [N];
  logic         trg  [N];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dut
    cdt_timer #(.W(W), .POLICY(pol_of(g))) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .start_oneshot(start_oneshot), .stop(stop), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
      .lim_reload(lim_reload), .count(cnt[g]), .rd_count(rdv[g]),
      .mode(md[g]), .trigger(trg[g])
    );
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    tick = 0; start = 0; start_oneshot = 0; stop = 0;
    cnt_wr = 0; lim_wr = 0; lim_reload = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int ntr [N];
    int keep [N];
    int exp_t [N];
    int exp_c [N];
    int exp_m [N];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      check("R1", "reset count", cnt[i], 0);
      check("R1", "reset mode", md[i], 0);
      check("R1", "reset trigger", trg[i], 0);
      check("R1", "reset readback", rdv[i], 0);
    end

    // R2 / R7 / R13 sweep over limits
    for (int L = 1; L <= 4; L++) begin
      idle(); stop = 1; step();
      idle(); lim_wr = 1; lim_wdata = W'(L); lim_reload = 1; step();
      idle(); start = 1; tick = 1; step();
      for (int i = 0; i < N; i++) begin
        check("R2", "count after start", cnt[i], L);
        check("R2", "mode after start", md[i], 1);
      end
      check("R13", "round-up readback fresh", rdv[6], L);
      idle(); tick = 1;
      for (int i = 0; i < N; i++) ntr[i] = 0;
      for (int k = 1; k <= 3 * L; k++) begin
        step();
        for (int i = 0; i < N; i++) if (trg[i]) ntr[i]++;
        if (k == 1 && L >= 2) begin
          check("R13", "round-up readback running", rdv[6], L);
          check("R13", "default readback", rdv[0], L - 1);
        end
        if (k == 2 && L == 2) begin
          check("R7", "wrap hold count", cnt[3], 0);
          check("R7", "wrap hold no trigger", trg[3], 0);
          check("R2", "default reload", cnt[0], 2);
        end
      end
      for (int i = 0; i < N; i++) begin
        if (i == 3) check("R7", "wrap trigger count", ntr[i], (3 * L) / (L + 1));
        else        check("R2", "periodic trigger count", ntr[i], 3);
      end
      // R10 stop with start and tick in the same cycle
      for (int i = 0; i < N; i++) keep[i] = cnt[i];
      idle(); stop = 1; start = 1; tick = 1; step();
      for (int i = 0; i < N; i++) begin
        check("R10", "stop mode", md[i], 0);
        check("R10", "stop keeps count", cnt[i], keep[i]);
      end
    end

    // R3 one-shot
    idle(); cnt_wr = 1; cnt_wdata = 8'd3; step();
    idle(); start = 1; start_oneshot = 1; step();
    for (int i = 0; i < N; i++) check("R3", "one-shot mode", md[i], 2);
    idle(); tick = 1; step(); step(); step();
    for (int i = 0; i < N; i++) begin
      check("R3", "one-shot expiry trigger", trg[i], 1);
      check("R3", "one-shot expiry mode", md[i], 0);
      check("R3", "one-shot expiry count", cnt[i], 0);
    end
    step();
    for (int i = 0; i < N; i++) begin
      check("R3", "after expiry trigger", trg[i], 0);
      check("R3", "after expiry count", cnt[i], 0);
    end

    // R12 limit write without reload leaves count; then R4/R5/R6/R8 zero load
    idle(); lim_wr = 1; lim_wdata = 8'd5; step();
    for (int i = 0; i < N; i++) check("R12", "limit no reload count", cnt[i], 0);
    idle(); start = 1; cnt_wr = 1; cnt_wdata = 8'd0; step();
    exp_t = '{1, 0, 1, 1, 1, 0, 1};
    exp_c = '{5, 5, 0, 5, 5, 5, 5};
    for (int i = 0; i < N; i++) begin
      check(i == 5 ? "R8" : (i == 1 ? "R5" : (i == 2 ? "R6" : "R4")),
            "zero-load trigger", trg[i], exp_t[i]);
      check(i == 2 ? "R6" : "R4", "zero-load count", cnt[i], exp_c[i]);
      check("R4", "zero-load mode", md[i], 1);
    end
    idle(); tick = 1; step();
    exp_c = '{4, 4, 5, 4, 4, 4, 4};
    for (int i = 0; i < N; i++) begin
      check(i == 2 ? "R6" : "R2", "tick after zero-load count", cnt[i], exp_c[i]);
      check("R6", "tick after zero-load trigger", trg[i], 0);
    end

    // R12 writes while running, R11 restart
    idle(); tick = 1; lim_wr = 1; lim_wdata = 8'd7; lim_reload = 1; step();
    for (int i = 0; i < N; i++) check("R12", "limit reload while running", cnt[i], 7);
    idle(); lim_wr = 1; lim_wdata = 8'd2; step();
    for (int i = 0; i < N; i++) check("R12", "limit without reload", cnt[i], 7);
    idle(); tick = 1; cnt_wr = 1; cnt_wdata = 8'd9; step();
    for (int i = 0; i < N; i++) check("R12", "count write beats tick", cnt[i], 9);
    idle(); start = 1; start_oneshot = 1; step();
    for (int i = 0; i < N; i++) begin
      check("R11", "restart count", cnt[i], 9);
      check("R11", "restart mode", md[i], 2);
    end

    // R9 / R5 / R4 zero limit
    idle(); stop = 1; step();
    idle(); lim_wr = 1; lim_wdata = 8'd0; lim_reload = 1; step();
    idle(); start = 1; step();
    exp_t = '{1, 0, 1, 1, 1, 0, 1};
    exp_m = '{0, 1, 0, 0, 1, 0, 0};
    for (int i = 0; i < N; i++) begin
      check(i == 4 ? "R9" : "R4", "zero-limit start trigger", trg[i], exp_t[i]);
      check(i == 4 ? "R9" : "R5", "zero-limit start mode", md[i], exp_m[i]);
    end
    idle(); tick = 1;
    for (int i = 0; i < N; i++) ntr[i] = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      for (int i = 0; i < N; i++) if (trg[i]) ntr[i]++;
    end
    exp_t = '{0, 1, 0, 0, 4, 0, 0};
    exp_m = '{0, 0, 0, 0, 1, 0, 0};
    for (int i = 0; i < N; i++) begin
      check(i == 4 ? "R9" : "R5", "zero-limit tick triggers", ntr[i], exp_t[i]);
      check(i == 4 ? "R9" : "R5", "zero-limit final mode", md[i], exp_m[i]);
    end

    // write colliding with the expiring tick
    idle(); stop = 1; step();
    idle(); lim_wr = 1; lim_wdata = 8'd3; lim_reload = 1; step();
    idle(); start = 1; step();
    idle(); tick = 1; step(); step();
    check("R2", "count before collision", cnt[0], 1);
    idle(); tick = 1; cnt_wr = 1; cnt_wdata = 8'd6; step();
    check("R12", "collision count", cnt[0], 6);
    check("R12", "collision trigger", trg[0], 0);
    idle(); step();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule